// File: doc/BRIEF.md
# Bit-Serial Montgomery Modular Multiplier

This block forms the Montgomery product of two residues: given an odd modulus n and operands a and b, both already below n, it returns a·b·2^-W mod n. W is the operand width. The block uses no division and never builds the full double-width product. It walks through the bits of a one per clock, starting from the least significant bit. On each step it adds b to a running accumulator when the current bit is set. It then adds n if that sum is odd, and halves the result. After W such steps, one compare-and-subtract brings the value into range.

A caller pulses `start` with the operands on the inputs. It then waits for the single-cycle `done` pulse, which comes a fixed number of cycles later whatever the data. The result stays on `prod` until the next product completes. Conversion into and out of the Montgomery domain, and any exponentiation sequencing, belong to the logic around the block.

Top module: `mont_mul`

## Requirements
- R1: For odd n, with a < n and b < n, the result presented with `done` equals a·b·R^-1 mod n, where R = 2^W.
- R2: Every result presented with `done` is strictly below the modulus captured at start.
- R3: `done` is high for exactly one cycle. It rises exactly W+2 cycles after the cycle in which an accepted `start` was high.
- R4: `busy` is high from the cycle after an accepted `start` up to, but not including, the `done` cycle. `busy` and `done` are never high together.
- R5: `start` is accepted only while `busy` is low. A `start` pulse during `busy` changes neither the latency nor the result of the running product.
- R6: a, b and n are captured only when `start` is accepted. Changing them while `busy` is high has no effect on the result.
- R7: `prod` holds its value in every cycle in which `done` is low.
- R8: After reset, `busy` = 0, `done` = 0 and `prod` = 0.
- R9: The latency is independent of operand values, including zero operands and operands equal to n-1.
- R10: A zero operand gives a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a product; accepted when `busy` is low |
| op_a | input | W | Multiplier operand, scanned least significant bit first |
| op_b | input | W | Multiplicand operand |
| modulus | input | W | Odd modulus n |
| busy | output | 1 | Product in progress |
| done | output | 1 | One-cycle pulse marking a new result on `prod` |
| prod | output | W | Montgomery product, held between pulses |

## Verification
A product requested in cycle c is due in cycle c+W+2: one cycle to load, W iteration cycles, and one correction cycle whose register drives both `done` and `prod`. The bench drives inputs and samples outputs on falling edges. For each product it counts falling edges from the start cycle and records the first one at which `done` is high. It requires that to be W+2, requires exactly one `done` cycle in the window, and compares `prod` at that point with a value computed from the modular inverse of R. The same window is used while the inputs are scrambled and a spurious `start` is pulsed during `busy`. This shows that both leave the due cycle and the value unchanged.

// File: rtl/mont_pkg.sv
package mont_pkg;

    // Sequencer phases of one product
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOOP = 2'd1,
        PH_FIX  = 2'd2
    } mont_phase_e;

    // Control strobes issued by the sequencer to the datapath
    typedef struct packed {
        logic load;
        logic step;
        logic fix;
    } mont_ctl_t;

endpackage

// File: rtl/mont_step.sv
// One radix-2 iteration: add b if the scanned bit is set, add n if odd, halve.
module mont_step #(
    parameter int W = 64
) (
    input  logic [W+1:0] acc_in,
    input  logic         bit_a,
    input  logic [W-1:0] mul_b,
    input  logic [W-1:0] mod_n,
    output logic [W+1:0] acc_out
);
    localparam int SW = W + 3;

    logic [SW-1:0] part;
    logic [SW-1:0] total;
    logic          odd;

    always_comb begin
        part    = {1'b0, acc_in} + (bit_a ? {3'b000, mul_b} : '0);
        odd     = part[0];
        total   = part + (odd ? {3'b000, mod_n} : '0);
        acc_out = total[SW-1:1];
    end
endmodule

// File: rtl/mont_fix.sv
// Final correction: subtract n once when the accumulator is at or above it.
module mont_fix #(
    parameter int W = 64
) (
    input  logic [W+1:0] acc_in,
    input  logic [W-1:0] mod_n,
    output logic [W-1:0] res
);
    logic [W+1:0] ext_n;
    logic [W+1:0] diff;
    logic         ge;

    always_comb begin
        ext_n = {2'b00, mod_n};
        ge    = (acc_in >= ext_n);
        diff  = acc_in - ext_n;
        res   = ge ? diff[W-1:0] : acc_in[W-1:0];
    end
endmodule

// File: rtl/mont_seq.sv
// Fixed-length sequencer: load, W iterations, one correction cycle.
module mont_seq
    import mont_pkg::*;
#(
    parameter int W = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output mont_ctl_t ctl,
    output logic      busy,
    output logic      done
);
    localparam int            CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mont_phase_e   phase;
    logic [CW-1:0] iter;

    always_comb begin
        ctl.load = (phase == PH_IDLE) && start;
        ctl.step = (phase == PH_LOOP);
        ctl.fix  = (phase == PH_FIX);
        busy     = (phase != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            iter  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_LOOP;
                        iter  <= '0;
                    end
                end
                PH_LOOP: begin
                    iter <= iter + 1'b1;
                    if (iter == LAST) phase <= PH_FIX;
                end
                PH_FIX: begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mont_mul.sv
module mont_mul
    import mont_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] modulus,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] prod
);
    localparam int AW = W + 2;

    mont_ctl_t     ctl;
    logic [W-1:0]  a_sh;
    logic [W-1:0]  b_q;
    logic [W-1:0]  n_q;
    logic [AW-1:0] acc;
    logic [AW-1:0] acc_nxt;
    logic [W-1:0]  fixed;

    mont_seq #(.W(W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    mont_step #(.W(W)) u_step (
        .acc_in  (acc),
        .bit_a   (a_sh[0]),
        .mul_b   (b_q),
        .mod_n   (n_q),
        .acc_out (acc_nxt)
    );

    mont_fix #(.W(W)) u_fix (
        .acc_in (acc),
        .mod_n  (n_q),
        .res    (fixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_sh <= '0;
            b_q  <= '0;
            n_q  <= '0;
            acc  <= '0;
            prod <= '0;
        end else begin
            if (ctl.load) begin
                a_sh <= op_a;
                b_q  <= op_b;
                n_q  <= modulus;
                acc  <= '0;
            end
            if (ctl.step) begin
                acc  <= acc_nxt;
                a_sh <= a_sh >> 1;
            end
            if (ctl.fix) prod <= fixed;
        end
    end
endmodule

// File: rtl/mont_mul_chk.sv
module mont_mul_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] prod,
    input logic [W-1:0] mod_q
);
    localparam logic [15:0] DUE = 16'(W + 2);

    logic [15:0] since;

    always_ff @(posedge clk) begin
        if (rst) since <= '0;
        else if (start && !busy) since <= 16'd1;
        else if (done) since <= '0;
        else if (since != 16'd0) since <= since + 16'd1;
    end

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_latency_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (since == DUE));

    assert_busy_done_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_busy_after_start_R4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_result_range_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (prod < mod_q));

    assert_prod_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(prod));
endmodule

bind mont_mul mont_mul_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .prod  (prod),
    .mod_q (n_q)
);

// File: tb/mont_mul_bench.sv
`timescale 1ns/1ps
module mont_mul_bench;
    localparam int W = 8;
    localparam int R = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] modulus = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] prod;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    mont_mul #(.W(W)) u_mont_mul (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .modulus (modulus),
        .busy    (busy),
        .done    (done),
        .prod    (prod)
    );

    function automatic int expect_prod(int a, int b, int n);
        int rinv = 0;
        for (int r = 0; r < n; r++) begin
            if (((r * R) % n) == (1 % n)) begin
                rinv = r;
                break;
            end
        end
        return (((a * b) % n) * rinv) % n;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One product; disturb = scramble inputs and pulse start while busy
    task automatic run_op(int a, int b, int n, bit disturb);
        int lat = 0;
        int pulses = 0;
        int got = 0;
        int exp;
        exp = expect_prod(a, b, n);
        @(negedge clk);
        op_a    = W'(a);
        op_b    = W'(b);
        modulus = W'(n);
        start   = 1'b1;
        for (int k = 1; k <= W + 3; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (disturb) begin
                op_a    = W'(a ^ (k * 37));
                op_b    = W'(~b);
                modulus = W'(n + 2 * k);
                if (k == 3) start = 1'b1;
            end
            if (k == 1) check(busy == 1'b1, "R4 busy after start", int'(busy), 1);
            if (done) begin
                pulses++;
                if (lat == 0) begin
                    lat = k;
                    got = int'(prod);
                    check(busy == 1'b0, "R4 busy low at done", int'(busy), 0);
                end
            end
        end
        start = 1'b0;
        check(lat == W + 2, disturb ? "R5 latency with start during busy" : "R3/R9 latency",
              lat, W + 2);
        check(pulses == 1, "R3 single done pulse", pulses, 1);
        check(got == exp, disturb ? "R6 result with inputs changed" : "R1 product", got, exp);
        check(got < n, "R2 range", got, n - 1);
        if (a == 0 || b == 0) check(got == 0, "R10 zero operand", got, 0);
    endtask

    initial begin
        #1_500_000;
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R8 reset busy", int'(busy), 0);
        check(done == 1'b0, "R8 reset done", int'(done), 0);
        check(prod == '0, "R8 reset prod", int'(prod), 0);

        // Exhaustive sweep over all small odd moduli
        for (int n = 1; n < 16; n += 2)
            for (int a = 0; a < n; a++)
                for (int b = 0; b < n; b++)
                    run_op(a, b, n, 1'b0);

        // Large moduli, corner operands, and disturbed inputs
        for (int s = 0; s < 4; s++) begin
            int n;
            n = (s == 0) ? 255 : (s == 1) ? 251 : (s == 2) ? 129 : 193;
            for (int a = 0; a < n; a += 23)
                for (int b = 0; b < n; b += 29)
                    run_op(a, b, n, (a % 2) == 1);
            run_op(n - 1, n - 1, n, 1'b0);
            run_op(n - 1, n - 1, n, 1'b1);
            run_op(0, n - 1, n, 1'b0);
        end

        // Result held while idle and while the next product runs
        run_op(200, 77, 251, 1'b0);
        begin
            int held;
            int exp;
            exp = expect_prod(200, 77, 251);
            held = int'(prod);
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                check(int'(prod) == exp, "R7 prod held idle", int'(prod), exp);
            end
            @(negedge clk);
            op_a = 8'd3; op_b = 8'd5; modulus = 8'd7; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < W; k++) begin
                @(negedge clk);
                if (!done) check(int'(prod) == held, "R7 prod held busy", int'(prod), held);
            end
            repeat (4) @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule